// File: doc/BRIEF.md
# Register Redirection Tag Table

This block holds a small set of register tags and uses them to remap 5-bit architectural register operands onto a 7-bit physical register space of 128 registers. Each tag is keyed by a register number and a register class: integer or floating-point. A tag supplies the physical target, a flag that marks the target as a vector or a scalar, and a 2-bit element-width override. An operand that no tag names passes through unchanged as a scalar. It is marked inactive, so it does not start the element loop.

Tags arrive one per cycle on a load port, in one of two word formats. The full 16-bit format names the target explicitly and can mark it scalar. The compact 8-bit format always yields a vector whose target is the register number times four. The table has a fixed capacity and is not searched as a list. Each accepted load writes straight into an expanded array indexed by class and register number, so a later tag for the same key replaces the earlier one. Three lookup ports, one each for the destination and the two sources, read that array in parallel within the same cycle.

A small fill-control machine counts the accepted loads. It has three states:
- EMPTY: no tag is held. On an accepted load it moves to FILLING, or to FULL when the capacity is one.
- FILLING: it moves to FULL when the load that reaches the capacity is accepted.
- FULL: further loads are refused and the state holds.

A clear sends every state back to EMPTY and wipes all tags.

Top module: `regtag_table`

## Requirements
- R1: After reset every lookup port reports pass-through: the physical number equals the operand zero-extended, the vector flag is 0, the width code is 00 and the active flag is 0.
- R2: Full-format load word: bits 4..0 hold the register number, bit 5 holds the class (1 = integer, 0 = floating-point), bits 7..6 hold the width code, bits 14..8 hold the target and bit 15 set means scalar. A matching lookup returns that target with active = 1 and vector = NOT bit 15.
- R3: Compact-format load word (with `ld_compact` = 1): bits 4..0 hold the register number, bit 5 holds the class and bits 7..6 hold the width code. Bits 15..8 are ignored. A matching lookup returns vector = 1 and target = register number shifted left by two.
- R4: A tag applies only to lookups of its own class. The same register number in the other class passes through.
- R5: The width output repeats the tag's 2-bit code: 00 = default width, 01 = 8 bits, 10 = 16 bits, 11 = 32 bits.
- R6: A lookup with no matching tag passes through as described in R1.
- R7: At most NUM_SLOTS loads are accepted after reset or a clear. Loads beyond that have no effect, including loads whose key is already held.
- R8: A clear empties every tag from the next cycle on. A clear takes precedence over a load in the same cycle.
- R9: When two accepted loads name the same key, the later one determines the lookup result.
- R10: The three lookup ports are independent, and each returns the result for its own operand in the same cycle.
- R11: A load is visible to lookups from the cycle after it is accepted, not in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Empty the table |
| ld_valid | input | 1 | Load word present |
| ld_compact | input | 1 | 1 = compact 8-bit format in bits 7..0 |
| ld_word | input | 16 | Tag load word |
| rd_reg | input | 5 | Destination operand |
| rd_int | input | 1 | Destination class, 1 = integer |
| rs1_reg | input | 5 | Source 1 operand |
| rs1_int | input | 1 | Source 1 class |
| rs2_reg | input | 5 | Source 2 operand |
| rs2_int | input | 1 | Source 2 class |
| rd_phys | output | 7 | Redirected destination |
| rd_vec | output | 1 | Destination is a vector |
| rd_elw | output | 2 | Destination width code |
| rd_active | output | 1 | Destination matched a tag |
| rs1_phys | output | 7 | Redirected source 1 |
| rs1_vec | output | 1 | Source 1 is a vector |
| rs1_elw | output | 2 | Source 1 width code |
| rs1_active | output | 1 | Source 1 matched a tag |
| rs2_phys | output | 7 | Redirected source 2 |
| rs2_vec | output | 1 | Source 2 is a vector |
| rs2_elw | output | 2 | Source 2 width code |
| rs2_active | output | 1 | Source 2 matched a tag |

## Verification
The hardest situation to reach is the FULL state with loads still arriving, because a refused load leaves no direct trace at the ports. The stimulus clears the table and then fills every slot with distinct keys. It then offers one load for a fresh key and one load that rewrites an existing key, and checks through the lookups that both are refused. A clear presented in the same cycle as a load is also covered, as is a lookup of a key in the very cycle its load is presented.

// File: rtl/regtag_pkg.sv
package regtag_pkg;
    localparam int ARCH_W  = 5;
    localparam int PHYS_W  = 7;
    localparam int LOAD_W  = 16;
    localparam int CLASSES = 2;
    localparam int IDX_W   = ARCH_W + $clog2(CLASSES);
    localparam int DEPTH   = CLASSES << ARCH_W;
    localparam int NPORTS  = 3;

    typedef enum logic [1:0] {
        ELW_DEFAULT = 2'b00,
        ELW_8       = 2'b01,
        ELW_16      = 2'b10,
        ELW_32      = 2'b11
    } elw_e;

    typedef struct packed {
        logic              used;
        logic              vec;
        elw_e              elw;
        logic [PHYS_W-1:0] phys;
    } slot_t;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FILLING = 2'd1,
        ST_FULL    = 2'd2
    } fill_e;
endpackage

// File: rtl/regtag_decode.sv
module regtag_decode
    import regtag_pkg::*;
(
    input  logic [LOAD_W-1:0] word,
    input  logic              compact,
    output logic [IDX_W-1:0]  key,
    output slot_t             slot
);
    always_comb begin
        key       = {word[ARCH_W], word[ARCH_W-1:0]};
        slot.used = 1'b1;
        slot.elw  = elw_e'(word[ARCH_W+2:ARCH_W+1]);
        if (compact) begin
            slot.vec  = 1'b1;
            slot.phys = PHYS_W'({word[ARCH_W-1:0], 2'b00});
        end else begin
            slot.vec  = ~word[LOAD_W-1];
            slot.phys = word[LOAD_W-2:LOAD_W-1-PHYS_W];
        end
    end
endmodule

// File: rtl/regtag_store.sv
module regtag_store
    import regtag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  slot_t            wdata,
    input  logic [IDX_W-1:0] ridx  [NPORTS],
    output slot_t            rdata [NPORTS]
);
    slot_t tbl [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else if (we) begin
            tbl[widx] <= wdata;
        end
    end

    always_comb begin
        for (int p = 0; p < NPORTS; p++) rdata[p] = tbl[ridx[p]];
    end

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (tbl[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/regtag_port.sv
module regtag_port
    import regtag_pkg::*;
(
    input  logic [ARCH_W-1:0] op_reg,
    input  slot_t             slot,
    output logic [PHYS_W-1:0] phys,
    output logic              vec,
    output logic [1:0]        elw,
    output logic              active
);
    always_comb begin
        if (slot.used) begin
            phys   = slot.phys;
            vec    = slot.vec;
            elw    = slot.elw;
            active = 1'b1;
        end else begin
            phys   = PHYS_W'(op_reg);
            vec    = 1'b0;
            elw    = ELW_DEFAULT;
            active = 1'b0;
        end
    end

    // R6
    always_comb begin
        if (!active) begin
            passthru_chk: assert (phys == PHYS_W'(op_reg) && !vec && elw == 2'b00);
        end
    end
endmodule

// File: rtl/regtag_table.sv
module regtag_table
    import regtag_pkg::*;
#(
    parameter int NUM_SLOTS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        ld_valid,
    input  logic        ld_compact,
    input  logic [15:0] ld_word,
    input  logic [4:0]  rd_reg,
    input  logic        rd_int,
    input  logic [4:0]  rs1_reg,
    input  logic        rs1_int,
    input  logic [4:0]  rs2_reg,
    input  logic        rs2_int,
    output logic [6:0]  rd_phys,
    output logic        rd_vec,
    output logic [1:0]  rd_elw,
    output logic        rd_active,
    output logic [6:0]  rs1_phys,
    output logic        rs1_vec,
    output logic [1:0]  rs1_elw,
    output logic        rs1_active,
    output logic [6:0]  rs2_phys,
    output logic        rs2_vec,
    output logic [1:0]  rs2_elw,
    output logic        rs2_active
);
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_SLOTS - 1);

    fill_e            st, st_nxt;
    logic [CNT_W-1:0] cnt;
    logic             accept;

    logic [IDX_W-1:0] wkey;
    slot_t            wslot;

    logic [ARCH_W-1:0] q_reg  [NPORTS];
    logic              q_int  [NPORTS];
    logic [IDX_W-1:0]  q_idx  [NPORTS];
    slot_t             q_slot [NPORTS];
    logic [PHYS_W-1:0] o_phys [NPORTS];
    logic              o_vec  [NPORTS];
    logic [1:0]        o_elw  [NPORTS];
    logic              o_act  [NPORTS];

    // fill-control: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_EMPTY;
            cnt <= '0;
        end else begin
            st <= st_nxt;
            if (clr)         cnt <= '0;
            else if (accept) cnt <= cnt + 1'b1;
        end
    end

    // fill-control: next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_EMPTY:   if (accept) st_nxt = (NUM_SLOTS == 1) ? ST_FULL : ST_FILLING;
            ST_FILLING: if (accept && cnt == LAST) st_nxt = ST_FULL;
            ST_FULL:    st_nxt = ST_FULL;
            default:    st_nxt = ST_EMPTY;
        endcase
        if (clr) st_nxt = ST_EMPTY;
    end

    // fill-control: outputs
    always_comb begin
        accept = 1'b0;
        unique case (st)
            ST_EMPTY, ST_FILLING: accept = ld_valid && !clr;
            ST_FULL:              accept = 1'b0;
            default:              accept = 1'b0;
        endcase
    end

    regtag_decode u_decode (
        .word    (ld_word),
        .compact (ld_compact),
        .key     (wkey),
        .slot    (wslot)
    );

    assign q_reg[0] = rd_reg;   assign q_int[0] = rd_int;
    assign q_reg[1] = rs1_reg;  assign q_int[1] = rs1_int;
    assign q_reg[2] = rs2_reg;  assign q_int[2] = rs2_int;

    regtag_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .we    (accept),
        .widx  (wkey),
        .wdata (wslot),
        .ridx  (q_idx),
        .rdata (q_slot)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign q_idx[p] = {q_int[p], q_reg[p]};
        regtag_port u_port (
            .op_reg (q_reg[p]),
            .slot   (q_slot[p]),
            .phys   (o_phys[p]),
            .vec    (o_vec[p]),
            .elw    (o_elw[p]),
            .active (o_act[p])
        );
    end

    assign rd_phys  = o_phys[0]; assign rd_vec  = o_vec[0]; assign rd_elw  = o_elw[0]; assign rd_active  = o_act[0];
    assign rs1_phys = o_phys[1]; assign rs1_vec = o_vec[1]; assign rs1_elw = o_elw[1]; assign rs1_active = o_act[1];
    assign rs2_phys = o_phys[2]; assign rs2_vec = o_vec[2]; assign rs2_elw = o_elw[2]; assign rs2_active = o_act[2];

    // R7
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FULL && !clr) |=> (st == ST_FULL));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt) <= NUM_SLOTS));

    // R8
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!rd_active && !rs1_active && !rs2_active));
endmodule

// File: tb/regtag_table_tb.sv
module regtag_table_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOTS     = 16;

    typedef struct packed {
        logic        ld;
        logic        cmp;
        logic [15:0] word;
        logic [4:0]  lreg;
        logic        lint;
        logic [6:0]  ephys;
        logic        evec;
        logic [1:0]  eelw;
        logic        eact;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 16'h6463, 5'd3,  1'b1, 7'd100, 1'b1, 2'b01, 1'b1, 4'd2}, // R2 R5 vector full
        '{1'b1, 1'b0, 16'hCDA4, 5'd4,  1'b1, 7'd77,  1'b0, 2'b10, 1'b1, 4'd2}, // R2 scalar full
        '{1'b1, 1'b1, 16'h00C5, 5'd5,  1'b0, 7'd20,  1'b1, 2'b11, 1'b1, 4'd3}, // R3 compact fp
        '{1'b1, 1'b1, 16'hFF3F, 5'd31, 1'b1, 7'd124, 1'b1, 2'b00, 1'b1, 4'd3}, // R3 compact, high byte ignored
        '{1'b0, 1'b0, 16'h0000, 5'd5,  1'b1, 7'd5,   1'b0, 2'b00, 1'b0, 4'd4}, // R4 other class
        '{1'b0, 1'b0, 16'h0000, 5'd3,  1'b0, 7'd3,   1'b0, 2'b00, 1'b0, 4'd4}, // R4 other class
        '{1'b1, 1'b0, 16'h0923, 5'd3,  1'b1, 7'd9,   1'b1, 2'b00, 1'b1, 4'd9}, // R9 later wins
        '{1'b0, 1'b0, 16'h0000, 5'd10, 1'b1, 7'd10,  1'b0, 2'b00, 1'b0, 4'd6}  // R6 no tag
    };

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic ld_valid = 1'b0, ld_compact = 1'b0;
    logic [15:0] ld_word = '0;
    logic [4:0] rd_reg = '0, rs1_reg = '0, rs2_reg = '0;
    logic rd_int = 1'b0, rs1_int = 1'b0, rs2_int = 1'b0;
    logic [6:0] rd_phys, rs1_phys, rs2_phys;
    logic rd_vec, rs1_vec, rs2_vec, rd_active, rs1_active, rs2_active;
    logic [1:0] rd_elw, rs1_elw, rs2_elw;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regtag_table #(.NUM_SLOTS(NSLOTS)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ld_valid(ld_valid), .ld_compact(ld_compact), .ld_word(ld_word),
        .rd_reg(rd_reg), .rd_int(rd_int), .rs1_reg(rs1_reg), .rs1_int(rs1_int),
        .rs2_reg(rs2_reg), .rs2_int(rs2_int),
        .rd_phys(rd_phys), .rd_vec(rd_vec), .rd_elw(rd_elw), .rd_active(rd_active),
        .rs1_phys(rs1_phys), .rs1_vec(rs1_vec), .rs1_elw(rs1_elw), .rs1_active(rs1_active),
        .rs2_phys(rs2_phys), .rs2_vec(rs2_vec), .rs2_elw(rs2_elw), .rs2_active(rs2_active)
    );

    function automatic logic [15:0] full_word(input logic scalar, input logic [6:0] tgt,
                                              input logic [1:0] elw, input logic isint,
                                              input logic [4:0] r);
        return {scalar, tgt, elw, isint, r};
    endfunction

    task automatic chk_port(input int p, input logic [6:0] ephys, input logic evec,
                            input logic [1:0] eelw, input logic eact, input string tag);
        logic [10:0] act, exp;
        case (p)
            0: act = {rd_phys, rd_vec, rd_elw, rd_active};
            1: act = {rs1_phys, rs1_vec, rs1_elw, rs1_active};
            default: act = {rs2_phys, rs2_vec, rs2_elw, rs2_active};
        endcase
        exp = {ephys, evec, eelw, eact};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s port%0d: got phys=%0d vec=%b elw=%b act=%b, exp phys=%0d vec=%b elw=%b act=%b",
                     tag, p, act[10:4], act[3], act[2:1], act[0], ephys, evec, eelw, eact);
        end
    endtask

    task automatic do_load(input logic cmp, input logic [15:0] w);
        @(negedge clk);
        ld_valid = 1'b1; ld_compact = cmp; ld_word = w;
        @(negedge clk);
        ld_valid = 1'b0; ld_compact = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic look(input logic [4:0] r, input logic i);
        rd_reg = r; rd_int = i; #1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout, exp completion");
            summary();
        end
    end

    initial begin
        rd_reg = 5'd7; rd_int = 1'b1; rs1_reg = 5'd0; rs1_int = 1'b0; rs2_reg = 5'd31; rs2_int = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state on all ports
        chk_port(0, 7'd7, 1'b0, 2'b00, 1'b0, "R1");
        chk_port(1, 7'd0, 1'b0, 2'b00, 1'b0, "R1");
        chk_port(2, 7'd31, 1'b0, 2'b00, 1'b0, "R1");

        // vector table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].ld) do_load(VECS[i].cmp, VECS[i].word);
            @(negedge clk);
            look(VECS[i].lreg, VECS[i].lint);
            chk_port(0, VECS[i].ephys, VECS[i].evec, VECS[i].eelw, VECS[i].eact,
                     $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R10 three ports at once
        @(negedge clk);
        rd_reg = 5'd3; rd_int = 1'b1; rs1_reg = 5'd5; rs1_int = 1'b0; rs2_reg = 5'd4; rs2_int = 1'b1;
        #1;
        chk_port(0, 7'd9, 1'b1, 2'b00, 1'b1, "R10");
        chk_port(1, 7'd20, 1'b1, 2'b11, 1'b1, "R10");
        chk_port(2, 7'd77, 1'b0, 2'b10, 1'b1, "R10");

        // R11 not visible in the cycle presented, visible after
        @(negedge clk);
        ld_valid = 1'b1; ld_compact = 1'b0; ld_word = full_word(1'b0, 7'd55, 2'b01, 1'b1, 5'd6);
        look(5'd6, 1'b1);
        chk_port(0, 7'd6, 1'b0, 2'b00, 1'b0, "R11");
        @(posedge clk); #1;
        chk_port(0, 7'd55, 1'b1, 2'b01, 1'b1, "R11");
        @(negedge clk); ld_valid = 1'b0;

        // R8 clear empties the table
        do_clear();
        look(5'd3, 1'b1);
        chk_port(0, 7'd3, 1'b0, 2'b00, 1'b0, "R8");
        look(5'd6, 1'b1);
        chk_port(0, 7'd6, 1'b0, 2'b00, 1'b0, "R8");

        // R8 clear beats a load in the same cycle
        @(negedge clk);
        clr = 1'b1; ld_valid = 1'b1; ld_word = full_word(1'b0, 7'd88, 2'b11, 1'b1, 5'd12);
        @(negedge clk);
        clr = 1'b0; ld_valid = 1'b0;
        look(5'd12, 1'b1);
        chk_port(0, 7'd12, 1'b0, 2'b00, 1'b0, "R8");

        // R7 fill all slots, then extra loads are refused
        for (int k = 0; k < NSLOTS; k++)
            do_load(1'b0, full_word(1'b0, 7'(64 + k), 2'b10, 1'b1, 5'(k)));
        do_load(1'b0, full_word(1'b0, 7'd120, 2'b01, 1'b1, 5'd20));
        do_load(1'b0, full_word(1'b1, 7'd121, 2'b11, 1'b1, 5'd0));
        look(5'd20, 1'b1);
        chk_port(0, 7'd20, 1'b0, 2'b00, 1'b0, "R7");
        look(5'd0, 1'b1);
        chk_port(0, 7'd64, 1'b1, 2'b10, 1'b1, "R7");
        look(5'(NSLOTS - 1), 1'b1);
        chk_port(0, 7'(64 + NSLOTS - 1), 1'b1, 2'b10, 1'b1, "R7");

        // R7 after clear, loads are accepted again
        do_clear();
        do_load(1'b1, 16'h0034);
        look(5'd20, 1'b1);
        chk_port(0, 7'd80, 1'b1, 2'b00, 1'b1, "R7");

        finished = 1'b1;
        summary();
    end
endmodule